// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Resend

This block sends single characters over a half-duplex, open-drain serial line of the kind used toward smart cards. Software places a byte in a holding register while the empty flag is high. On the next cycle the block starts a frame. The frame is a low start bit, the eight data bits with the least significant first, and an even parity bit. After the parity bit the block releases the line and listens. A receiver that rejects the character holds the line low in the slot after parity.

When such a rejection is seen, the block raises a sticky error flag. It then sends the same byte again from the holding register, with no software action. The end-of-transfer flag and the empty flag rise together only after a frame draws no rejection. That moment depends on a guard select: 12.5 bit times after the start bit begins, or 11.0 bit times in the short-guard setting. The bit time is a cycle count taken from an input when each frame starts. Two level interrupt outputs follow the end-of-transfer and error flags, each gated by its own enable.

Top module: `sctx_top`

## Requirements
- R1: A frame drives the line low for the start bit (slot 0), then D0..D7 in slots 1 to 8, then in slot 9 a parity bit equal to the XOR of the eight data bits (even parity). A 0 bit asserts `pad_pull_low`. From slot 10 on, and whenever `tx_done` is 1, `pad_pull_low` is 0.
- R2: Each slot lasts `bit_period` clock cycles. The value is captured when the frame starts, and values below 4 count as 4.
- R3: A write (`wr_en`=1) is taken only while `hold_empty` is 1, and it clears `hold_empty` at the next edge. The start bit begins on the edge after that. Writes while `hold_empty` is 0 are ignored.
- R4: The line is sampled once, at cycle `bit_period/2` (integer division) of slot 10. If it is low there, `err_flag` becomes 1 on the following edge.
- R5: A frame that drew an error is followed at once by a resend of the same byte. The new start bit begins at the frame's end point given in R6. `tx_done` and `hold_empty` stay 0 throughout.
- R6: A frame with no error sets `tx_done` and `hold_empty` on the same edge. With `guard_short`=0 this is 12*`bit_period` + `bit_period/2` cycles after the start-bit edge. With `guard_short`=1 it is 11*`bit_period` cycles after that edge. `guard_short` is captured at frame start.
- R7: `err_flag` is cleared only by `err_clr`=1. When a new error and `err_clr` arrive in the same cycle, the flag stays 1.
- R8: `tx_irq` equals `tx_irq_en` AND `tx_done`. `err_irq` equals `err_irq_en` AND `err_flag`.
- R9: After reset, `hold_empty`=1, `tx_done`=1, `err_flag`=0 and `pad_pull_low`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_period | input | 16 | Clock cycles per bit slot, minimum 4 |
| guard_short | input | 1 | 1 selects the 11.0 bit-time end point, 0 selects 12.5 |
| tx_irq_en | input | 1 | Enable for the transfer-end interrupt |
| err_irq_en | input | 1 | Enable for the error interrupt |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| pad_sense | input | 1 | Level seen on the shared line |
| pad_pull_low | output | 1 | 1 pulls the open-drain line low |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_done | output | 1 | Last character finished without error |
| err_flag | output | 1 | Sticky receiver-rejection flag |
| tx_irq | output | 1 | Transfer-end interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
On every cycle the assertions check four things. An empty holding register implies transfer end, and the two flags rise together. The line is released whenever a transfer has ended. A write that empties nothing is followed by a start bit on the next edge. The error flag rises only after a low line and falls only with a clear strobe. The bit order, the parity value, the exact end-point cycle for each guard setting, the resend of the identical byte and the set-beats-clear collision depend on a whole frame. Only the bench's scenarios show these, with its card model returning a set number of rejections.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  typedef enum logic {TX_IDLE, TX_FRAME} tx_state_e;
  // slots after the last data slot: parity, then the listening slot
  localparam int unsigned SC_PARITY_SLOTS = 1;
endpackage

// File: rtl/sctx_bitclock.sv
module sctx_bitclock #(
  parameter int unsigned PW         = 16,
  parameter int unsigned SW         = 4,
  parameter int unsigned ERR_SLOT   = 10,
  parameter int unsigned MIN_PERIOD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_go,
  input  logic          busy,
  input  logic [PW-1:0] period_in,
  input  logic          short_in,
  output logic [SW-1:0] slot,
  output logic          wrap,
  output logic          sample_hit,
  output logic          end_hit
);
  localparam logic [SW-1:0] ERR_S  = SW'(ERR_SLOT);
  localparam logic [SW-1:0] LONG_S = SW'(ERR_SLOT + 2);
  localparam logic [PW-1:0] MINP   = PW'(MIN_PERIOD);

  logic [PW-1:0] per_q, cyc_q, half;
  logic [SW-1:0] slot_q;
  logic          short_q;

  assign half = per_q >> 1;
  assign wrap = (cyc_q == per_q - 1'b1);
  assign slot = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= MINP;
      cyc_q   <= '0;
      slot_q  <= '0;
      short_q <= 1'b0;
    end else if (start_go) begin
      per_q   <= (period_in < MINP) ? MINP : period_in;
      short_q <= short_in;
      cyc_q   <= '0;
      slot_q  <= '0;
    end else if (busy) begin
      if (wrap) begin
        cyc_q  <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign sample_hit = busy && (slot_q == ERR_S) && (cyc_q == half);

  always_comb begin
    if (short_q) end_hit = busy && (slot_q == ERR_S) && wrap;
    else         end_hit = busy && (slot_q == LONG_S) && (cyc_q == half - 1'b1);
  end
endmodule

// File: rtl/sctx_shifter.sv
module sctx_shifter #(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          wrap,
  input  logic [SW-1:0] slot,
  input  logic          stop,
  output logic          pull_low
);
  localparam logic [SW-1:0] LAST_DATA = SW'(DW);
  localparam logic [SW-1:0] PAR_SLOT  = SW'(DW + 1);

  logic [DW-1:0] sh_q;
  logic          par_q;
  logic [SW-1:0] nslot;

  assign nslot = slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      par_q    <= 1'b0;
      pull_low <= 1'b0;
    end else if (load) begin
      sh_q     <= din;
      par_q    <= ^din;
      pull_low <= 1'b1;
    end else if (stop) begin
      pull_low <= 1'b0;
    end else if (wrap) begin
      if (nslot != '0 && nslot <= LAST_DATA) begin
        pull_low <= ~sh_q[0];
        sh_q     <= sh_q >> 1;
      end else if (nslot == PAR_SLOT) begin
        pull_low <= ~par_q;
      end else begin
        pull_low <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sctx_flags.sv
module sctx_flags #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          start_go,
  input  logic          finish_ok,
  input  logic          err_hit,
  input  logic          err_clr,
  output logic [DW-1:0] hold_q,
  output logic          hold_empty,
  output logic          tx_done,
  output logic          err_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_empty <= 1'b1;
      tx_done    <= 1'b1;
      err_flag   <= 1'b0;
    end else begin
      if (wr_en && hold_empty) begin
        hold_q     <= wr_data;
        hold_empty <= 1'b0;
      end else if (finish_ok) begin
        hold_empty <= 1'b1;
      end
      if (finish_ok)     tx_done <= 1'b1;
      else if (start_go) tx_done <= 1'b0;
      if (err_hit)       err_flag <= 1'b1;
      else if (err_clr)  err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sctx_top.sv
module sctx_top #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] bit_period,
  input  logic          guard_short,
  input  logic          tx_irq_en,
  input  logic          err_irq_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          err_clr,
  input  logic          pad_sense,
  output logic          pad_pull_low,
  output logic          hold_empty,
  output logic          tx_done,
  output logic          err_flag,
  output logic          tx_irq,
  output logic          err_irq
);
  import sctx_pkg::*;

  localparam int unsigned ERR_SLOT = DW + 1 + SC_PARITY_SLOTS;
  localparam int unsigned SW       = $clog2(ERR_SLOT + 3);

  tx_state_e     state_q;
  logic          err_seen_q;
  logic          start_go, finish_ok, err_hit, busy;
  logic          wrap, sample_hit, end_hit;
  logic [SW-1:0] slot;
  logic [DW-1:0] hold_q;

  assign busy      = (state_q == TX_FRAME);
  assign start_go  = (!busy && !hold_empty) || (end_hit && err_seen_q);
  assign finish_ok = end_hit && !err_seen_q;
  assign err_hit   = sample_hit && !pad_sense;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= TX_IDLE;
      err_seen_q <= 1'b0;
    end else begin
      if (start_go)       state_q <= TX_FRAME;
      else if (finish_ok) state_q <= TX_IDLE;
      if (start_go)       err_seen_q <= 1'b0;
      else if (err_hit)   err_seen_q <= 1'b1;
    end
  end

  sctx_bitclock #(.PW(PW), .SW(SW), .ERR_SLOT(ERR_SLOT), .MIN_PERIOD(4)) u_clk (
    .clk(clk), .rst(rst), .start_go(start_go), .busy(busy),
    .period_in(bit_period), .short_in(guard_short),
    .slot(slot), .wrap(wrap), .sample_hit(sample_hit), .end_hit(end_hit)
  );

  sctx_shifter #(.DW(DW), .SW(SW)) u_shift (
    .clk(clk), .rst(rst), .load(start_go), .din(hold_q),
    .wrap(wrap), .slot(slot), .stop(finish_ok), .pull_low(pad_pull_low)
  );

  sctx_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .start_go(start_go), .finish_ok(finish_ok), .err_hit(err_hit),
    .err_clr(err_clr), .hold_q(hold_q), .hold_empty(hold_empty),
    .tx_done(tx_done), .err_flag(err_flag)
  );

  assign tx_irq  = tx_irq_en && tx_done;
  assign err_irq = err_irq_en && err_flag;
endmodule

// File: rtl/sctx_chk.sv
module sctx_chk (
  input logic clk,
  input logic rst,
  input logic err_clr,
  input logic pad_sense,
  input logic pad_pull_low,
  input logic hold_empty,
  input logic tx_done,
  input logic err_flag
);
  // R6: an empty holding register means the last character has finished
  a_r6_empty_implies_done: assert property (@(posedge clk) disable iff (rst)
    hold_empty |-> tx_done);
  // R6: both flags rise on one edge
  a_r6_rise_together: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> $rose(hold_empty));
  // R1: line released once a transfer has ended
  a_r1_released_when_done: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !pad_pull_low);
  // R3: an accepted write leads to a start bit on the next edge
  a_r3_start_follows_write: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_empty) |=> (!tx_done && pad_pull_low));
  // R4: the error flag rises only after a low line
  a_r4_set_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> !$past(pad_sense));
  // R7: without a clear strobe the error flag holds
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind sctx_top sctx_chk u_chk (
  .clk(clk), .rst(rst), .err_clr(err_clr), .pad_sense(pad_sense),
  .pad_pull_low(pad_pull_low), .hold_empty(hold_empty),
  .tx_done(tx_done), .err_flag(err_flag)
);

// File: tb/tb_sctx_top.sv
`timescale 1ns/1ps
module tb_sctx_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bit_period = 16'd8;
  logic guard_short = 1'b0;
  logic tx_irq_en = 1'b0, err_irq_en = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic clr_main = 1'b0, clr_mon = 1'b0;
  logic card_pull = 1'b0;
  logic err_clr, pad_sense, pad_pull_low, hold_empty, tx_done, err_flag, tx_irq, err_irq;

  int n_chk = 0, n_err = 0, cur_p = 8;

  typedef struct {logic [7:0] d; int n; logic g; logic c;} item_t;
  item_t exp_q[$];

  assign err_clr   = clr_main | clr_mon;
  assign pad_sense = !(pad_pull_low || card_pull);

  always #2 clk = ~clk;

  sctx_top dut (
    .clk(clk), .rst(rst), .bit_period(bit_period), .guard_short(guard_short),
    .tx_irq_en(tx_irq_en), .err_irq_en(err_irq_en), .wr_en(wr_en),
    .wr_data(wr_data), .err_clr(err_clr), .pad_sense(pad_sense),
    .pad_pull_low(pad_pull_low), .hold_empty(hold_empty), .tx_done(tx_done),
    .err_flag(err_flag), .tx_irq(tx_irq), .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor with card model
  initial begin : mon
    item_t it;
    int tries, p, hh, el, endx;
    logic nack;
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (!rst && pad_sense === 1'b0) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected frame", 1, 0);
          continue;
        end
        it = exp_q.pop_front();
        tries = 0;
        do begin
          p = cur_p; hh = p / 2; el = 0;
          endx = it.g ? 11 * p : 12 * p + hh;
          nack = (tries < it.n);
          repeat (hh) begin @(negedge clk); el++; end
          chk("R1 start bit low", pad_sense, 0);
          for (int k = 0; k < 8; k++) begin
            repeat (p) begin @(negedge clk); el++; end
            got[k] = pad_sense;
          end
          chk("R1 R2 data bits", got, it.d);
          repeat (p) begin @(negedge clk); el++; end
          chk("R1 even parity bit", pad_sense, ^it.d);
          while (el < endx) begin
            @(negedge clk); el++;
            card_pull = nack && el >= 10 * p + 1 && el <= 10 * p + hh + 1;
            clr_mon   = it.c && nack && el == 10 * p + hh;
            if (el == 10 * p + 1) chk("R1 released after parity", pad_pull_low, 0);
            if (el == endx - 1) chk("R6 done not early", tx_done, 0);
          end
          card_pull = 1'b0; clr_mon = 1'b0;
          if (nack) begin
            chk("R5 resend start at end point", pad_sense, 0);
            chk("R5 done low during resend", tx_done, 0);
            chk("R5 holding kept during resend", hold_empty, 0);
            chk("R4 error flagged", err_flag, 1);
            tries++;
          end else begin
            chk("R6 done at end point", tx_done, 1);
            chk("R6 empty with done", hold_empty, 1);
            chk("R8 tx_irq", tx_irq, tx_irq_en);
          end
        end while (nack);
      end
    end
  end

  task automatic send(input logic [7:0] d, input int n, input logic g, input logic c);
    item_t it;
    it = '{d, n, g, c};
    guard_short = g;
    exp_q.push_back(it);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    chk("R3 write clears empty", hold_empty, 0);
    chk("R3 done until start", tx_done, 1);
    @(negedge clk);
    chk("R3 start bit next edge", pad_pull_low, 1);
    do @(negedge clk); while (!(tx_done && hold_empty));
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk); clr_main = 1'b1;
    @(negedge clk); clr_main = 1'b0;
    chk("R7 cleared by strobe", err_flag, 0);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    item_t it;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 hold_empty", hold_empty, 1);
    chk("R9 tx_done", tx_done, 1);
    chk("R9 err_flag", err_flag, 0);
    chk("R9 line released", pad_pull_low, 0);
    chk("R8 tx_irq disabled", tx_irq, 0);
    tx_irq_en = 1'b1; err_irq_en = 1'b1;
    @(negedge clk);
    chk("R8 tx_irq enabled", tx_irq, 1);
    chk("R8 err_irq idle", err_irq, 0);

    send(8'hA5, 0, 1'b0, 1'b0);
    send(8'h3C, 0, 1'b1, 1'b0);
    chk("R7 no error without rejection", err_flag, 0);

    send(8'h00, 1, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R7 flag sticky", err_flag, 1);
    chk("R8 err_irq", err_irq, 1);
    clear_err();
    chk("R8 err_irq after clear", err_irq, 0);

    send(8'hFF, 2, 1'b1, 1'b1);
    chk("R7 set wins over clear", err_flag, 1);
    clear_err();

    err_irq_en = 1'b0;
    send(8'hC3, 1, 1'b0, 1'b0);
    chk("R8 err_irq masked", err_irq, 0);
    clear_err();

    // R3: second write while full is ignored; monitor expects 0x81 only
    tx_irq_en = 1'b0;
    it = '{8'h81, 1, 1'b0, 1'b0};
    guard_short = 1'b0;
    exp_q.push_back(it);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h81;
    @(negedge clk); wr_data = 8'h7E;
    @(negedge clk); wr_en = 1'b0;
    chk("R3 ignored write keeps full", hold_empty, 0);
    do @(negedge clk); while (!(tx_done && hold_empty));
    repeat (2) @(negedge clk);
    chk("R8 tx_irq masked", tx_irq, 0);
    chk("R3 no extra frame", exp_q.size(), 0);
    clear_err();

    // R2: another bit period, odd value
    cur_p = 5; bit_period = 16'd5;
    tx_irq_en = 1'b1;
    send(8'h5A, 1, 1'b1, 1'b0);
    send(8'h96, 0, 1'b0, 1'b0);
    clear_err();

    // R2: period below the minimum counts as 4
    cur_p = 4; bit_period = 16'd2;
    send(8'h17, 0, 1'b0, 1'b0);

    repeat (20) @(negedge clk);
    chk("R5 all characters sent", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule